// File: doc/BRIEF.md
# Packet Receive FIFO with Abort

This block buffers received packets between a network receive path and a system-side reader. Both sides share one clock. Each stored entry is one 64-bit word carrying three tags: first word of a packet, last data word of a packet, and status word. The writer supplies the data words, then one status word per packet. A 3-bit end-mode setting decides which status words are kept and which word the reader sees as the end of the packet. The read side is show-ahead. The head word is presented with its tags while the read-valid output is high, and a read-enable pulse consumes it.

The reader can drop the packet it is in the middle of by pulsing an abort input. The block then removes the remaining words of that packet from storage, one per cycle, and waits a fixed six-cycle tail before it offers the next word. An accepted abort sets a sticky discard flag. Software clears that flag with a clear pulse, or the block clears it by itself when the next packet's first word is read. A configuration bit makes the block ignore the abort input. Two fullness watermarks, each with its own 9-bit threshold, are exported. A write into a full store is refused and reported with an overflow pulse.

Top module: `pkt_rx_fifo`

## Requirements
- R1: After reset, rd_valid, wr_ovf, disc_flag and both wm_out bits are low.
- R2: Words are read in the order written, with data and tags intact. A word written at a clock edge is offered (rd_valid high) right after that edge.
- R3: The store holds 512 words. A kept write while 512 words are stored is refused, and wr_ovf is high in that same cycle. The refused word never appears on the read side.
- R4: After every clock edge, wm_out[i] is high exactly when the stored word count exceeds threshold i. Threshold i is cfg_wm_thr[9*i+8:9*i], so bit 0 uses bits 8:0 and bit 1 uses bits 17:9.
- R5: End modes 000, 001, 010, 110 and 111 keep no status word (a write with wr_stat high is dropped). rd_eop is high on the last data word.
- R6: In end mode 011 the status word is kept and read after the data. rd_eop is high only on the status word and low on the last data word.
- R7: In end mode 100 the status word is kept and read after the data with rd_stat high and rd_eop low. rd_eop is high on the last data word.
- R8: In end mode 101, the status word of a packet that is read normally is removed without being offered. After an accepted abort, that packet's status word is offered with rd_stat and rd_eop high and rd_sop low.
- R9: An abort is accepted when cfg_abort_en is high and the reader has consumed the first word but not the final stored word of a packet. The final stored word is the status word in modes 011 and 100, and the last data word otherwise. Read-valid then stays low for R+6 cycles, where R is the number of that packet's words still stored. The next word offered follows the dropped packet. An abort takes priority over rd_en in the same cycle.
- R10: An abort has no effect when cfg_abort_en is low, or when no packet is in progress on the read side. The head word stays offered and disc_flag does not change.
- R11: disc_flag rises in the cycle after an accepted abort and stays high until cleared.
- R12: disc_flag clears on a disc_clr pulse, or (when cfg_autoclr is high) after the reader consumes a first-of-packet word. An accepted abort in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write strobe |
| wr_data | input | 64 | Word to store |
| wr_sop | input | 1 | Word is the first of a packet |
| wr_eop | input | 1 | Word is the last data word of a packet |
| wr_stat | input | 1 | Word is a status word |
| wr_ovf | output | 1 | Write refused because the store is full |
| rd_en | input | 1 | Consume the offered word |
| rd_valid | output | 1 | A word is offered |
| rd_data | output | 64 | Offered word |
| rd_sop | output | 1 | Offered word starts a packet |
| rd_eop | output | 1 | Offered word ends a packet for the reader |
| rd_stat | output | 1 | Offered word is a status word |
| rd_abort | input | 1 | Drop the packet being read |
| cfg_abort_en | input | 1 | Abort input honoured when high |
| cfg_end_mode | input | 3 | Status-word and end-marker mode |
| cfg_autoclr | input | 1 | Clear the discard flag on the next packet start |
| disc_clr | input | 1 | Clear pulse for the discard flag |
| disc_flag | output | 1 | Sticky packet-discarded indication |
| cfg_wm_thr | input | 18 | Two 9-bit watermark thresholds |
| wm_out | output | 2 | Watermark outputs |

## Verification
wr_ovf is combinational on the write strobe, so the bench samples it within the refused cycle, before the edge. A written word is offered, and the watermarks reflect the new count, directly after the edge that stores or removes it. The bench samples both one nanosecond after that edge. After an accepted abort, the bench counts consecutive low rd_valid samples starting just after the abort edge and expects exactly R+6 before the next word. disc_flag is checked one edge after the abort, the clear or the consuming read that changes it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    ST_PASS  = 2'd0,
    ST_FLUSH = 2'd1,
    ST_TAIL  = 2'd2
  } rxq_state_e;

  typedef struct packed {
    logic sop;
    logic last;
    logic stat;
  } rxq_tag_t;

  // status words are stored in these modes
  function automatic logic mode_keeps_status(input logic [2:0] m);
    return (m == 3'b011) || (m == 3'b100) || (m == 3'b101);
  endfunction

  // in these modes the status word is the packet's final stored entry
  function automatic logic mode_status_final(input logic [2:0] m);
    return (m == 3'b011) || (m == 3'b100);
  endfunction

  function automatic logic entry_is_final(input logic [2:0] m, input rxq_tag_t t);
    return mode_status_final(m) ? t.stat : t.last;
  endfunction

  // end marker seen by the reader
  function automatic logic reader_eop(input logic [2:0] m, input rxq_tag_t t);
    case (m)
      3'b011:  return t.stat;
      3'b101:  return t.last | t.stat;
      default: return t.last;
    endcase
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned ENT_W = 67,
  parameter int unsigned DEPTH = 512
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic [ENT_W-1:0]               din,
  input  logic                           pop,
  output logic [ENT_W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic [$clog2(DEPTH+1)-1:0]     count_nxt,
  output logic                           empty,
  output logic                           full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CW'(DEPTH));
  assign count     = cnt_q;
  assign count_nxt = cnt_q + CW'(push) - CW'(pop);
  assign dout      = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      cnt_q <= count_nxt;
    end
  end

  a_r3_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  a_r2_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);

endmodule

// File: rtl/rxq_wmark.sv
module rxq_wmark #(
  parameter int unsigned NUM_WM = 2,
  parameter int unsigned THR_W  = 9,
  parameter int unsigned CW     = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CW-1:0]            count_i,
  input  logic [CW-1:0]            count_nxt_i,
  input  logic [NUM_WM*THR_W-1:0]  thr_i,
  output logic [NUM_WM-1:0]        wm_o
);
  for (genvar g = 0; g < NUM_WM; g++) begin : g_wm
    logic [CW-1:0] thr_ext;
    logic          wm_r;

    assign thr_ext = CW'(thr_i[g*THR_W +: THR_W]);
    assign wm_o[g] = wm_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wm_r <= 1'b0;
      else        wm_r <= (count_nxt_i > thr_ext);
    end

    a_r4_wm_level: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(thr_ext) |-> (wm_r == (count_i > thr_ext)));
  end

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int unsigned TAIL_CYC = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  input  logic       abort_i,
  input  logic       abort_en_i,
  input  logic       autoclr_i,
  input  logic       clr_i,
  input  logic       head_valid_i,
  input  rxq_tag_t   head_tag_i,
  input  logic       rd_en_i,
  output logic       rd_valid_o,
  output logic       pop_o,
  output logic       disc_o
);
  localparam int unsigned OW = (TAIL_CYC > 1) ? $clog2(TAIL_CYC) : 1;

  rxq_state_e    state_q;
  logic [OW-1:0] tail_q;
  logic          pkt_act_q, disc_pend_q, disc_q;

  // named internal events
  logic head_final, skip_stat, abort_hit, user_pop, flush_pop, flush_done, sop_taken;

  assign head_final = entry_is_final(mode_i, head_tag_i);
  assign skip_stat  = (state_q == ST_PASS) && head_valid_i && head_tag_i.stat &&
                      (mode_i == 3'b101) && !disc_pend_q;
  assign rd_valid_o = (state_q == ST_PASS) && head_valid_i && !skip_stat;
  assign abort_hit  = abort_i && abort_en_i && pkt_act_q && (state_q == ST_PASS);
  assign user_pop   = rd_valid_o && rd_en_i && !abort_hit;
  assign flush_pop  = (state_q == ST_FLUSH) && head_valid_i;
  assign flush_done = flush_pop && head_final;
  assign sop_taken  = user_pop && head_tag_i.sop;
  assign pop_o      = user_pop || (skip_stat && !abort_hit) || flush_pop;
  assign disc_o     = disc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PASS;
      tail_q  <= '0;
    end else begin
      case (state_q)
        ST_PASS:  if (abort_hit) state_q <= ST_FLUSH;
        ST_FLUSH: if (flush_done) begin
                    state_q <= ST_TAIL;
                    tail_q  <= OW'(TAIL_CYC - 1);
                  end
        ST_TAIL:  if (tail_q == '0) state_q <= ST_PASS;
                  else              tail_q  <= tail_q - 1'b1;
        default:  state_q <= ST_PASS;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_act_q   <= 1'b0;
      disc_pend_q <= 1'b0;
      disc_q      <= 1'b0;
    end else begin
      if (flush_done)                     pkt_act_q <= 1'b0;
      else if (user_pop && head_final)    pkt_act_q <= 1'b0;
      else if (sop_taken)                 pkt_act_q <= 1'b1;

      if (abort_hit && mode_i == 3'b101)  disc_pend_q <= 1'b1;
      else if (user_pop && head_tag_i.stat) disc_pend_q <= 1'b0;

      if (abort_hit)                          disc_q <= 1'b1;
      else if (clr_i || (autoclr_i && sop_taken)) disc_q <= 1'b0;
    end
  end

  a_r9_enter_flush: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |=> (state_q == ST_FLUSH));
  a_r9_tail_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TAIL) |-> !pop_o);
  a_r10_abort_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && !abort_en_i && state_q == ST_PASS) |=> (state_q == ST_PASS));
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && !pkt_act_q && state_q == ST_PASS) |=> (state_q == ST_PASS));
  a_r11_disc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (disc_q && !clr_i && !(autoclr_i && sop_taken)) |=> disc_q);
  a_r12_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_hit && clr_i) |=> disc_q);

endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo
  import rxq_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned DEPTH    = 512,
  parameter int unsigned THR_W    = 9,
  parameter int unsigned NUM_WM   = 2,
  parameter int unsigned TAIL_CYC = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_valid,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    wr_sop,
  input  logic                    wr_eop,
  input  logic                    wr_stat,
  output logic                    wr_ovf,
  input  logic                    rd_en,
  output logic                    rd_valid,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    rd_sop,
  output logic                    rd_eop,
  output logic                    rd_stat,
  input  logic                    rd_abort,
  input  logic                    cfg_abort_en,
  input  logic [2:0]              cfg_end_mode,
  input  logic                    cfg_autoclr,
  input  logic                    disc_clr,
  output logic                    disc_flag,
  input  logic [NUM_WM*THR_W-1:0] cfg_wm_thr,
  output logic [NUM_WM-1:0]       wm_out
);
  localparam int unsigned TAG_W = $bits(rxq_tag_t);
  localparam int unsigned ENT_W = DATA_W + TAG_W;
  localparam int unsigned CW    = $clog2(DEPTH + 1);

  logic             wr_keep, push, pop, empty, full;
  logic [ENT_W-1:0] din, head;
  logic [CW-1:0]    count, count_nxt;
  rxq_tag_t         in_tag, head_tag;

  // write side: drop status words the mode does not keep
  assign wr_keep     = wr_valid && (!wr_stat || mode_keeps_status(cfg_end_mode));
  assign push        = wr_keep && !full;
  assign wr_ovf      = wr_keep && full;
  assign in_tag.sop  = wr_sop && !wr_stat;
  assign in_tag.last = wr_eop && !wr_stat;
  assign in_tag.stat = wr_stat;
  assign din         = {in_tag, wr_data};

  rxq_store #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .din(din), .pop(pop),
    .dout(head), .count(count), .count_nxt(count_nxt), .empty(empty), .full(full)
  );

  rxq_wmark #(.NUM_WM(NUM_WM), .THR_W(THR_W), .CW(CW)) u_wmark (
    .clk(clk), .rst_n(rst_n), .count_i(count), .count_nxt_i(count_nxt),
    .thr_i(cfg_wm_thr), .wm_o(wm_out)
  );

  assign head_tag = head[ENT_W-1 -: TAG_W];

  rxq_ctrl #(.TAIL_CYC(TAIL_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_i(cfg_end_mode), .abort_i(rd_abort),
    .abort_en_i(cfg_abort_en), .autoclr_i(cfg_autoclr), .clr_i(disc_clr),
    .head_valid_i(!empty), .head_tag_i(head_tag), .rd_en_i(rd_en),
    .rd_valid_o(rd_valid), .pop_o(pop), .disc_o(disc_flag)
  );

  assign rd_data = head[DATA_W-1:0];
  assign rd_sop  = rd_valid && head_tag.sop;
  assign rd_stat = rd_valid && head_tag.stat;
  assign rd_eop  = rd_valid && reader_eop(cfg_end_mode, head_tag);

endmodule

// File: tb/pkt_rx_fifo_bench.sv
`timescale 1ns/1ps
module pkt_rx_fifo_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid, wr_sop, wr_eop, wr_stat, wr_ovf;
  logic [63:0] wr_data, rd_data;
  logic        rd_en, rd_valid, rd_sop, rd_eop, rd_stat;
  logic        rd_abort, cfg_abort_en, cfg_autoclr, disc_clr, disc_flag;
  logic [2:0]  cfg_end_mode;
  logic [17:0] cfg_wm_thr;
  logic [1:0]  wm_out;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  pkt_rx_fifo u_pkt_rx_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_stat(wr_stat), .wr_ovf(wr_ovf),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .rd_sop(rd_sop),
    .rd_eop(rd_eop), .rd_stat(rd_stat), .rd_abort(rd_abort),
    .cfg_abort_en(cfg_abort_en), .cfg_end_mode(cfg_end_mode),
    .cfg_autoclr(cfg_autoclr), .disc_clr(disc_clr), .disc_flag(disc_flag),
    .cfg_wm_thr(cfg_wm_thr), .wm_out(wm_out)
  );

  // case vector: {end mode, data words, abort after N reads (0 = none), abort enable}
  localparam int NCASE = 11;
  localparam logic [11:0] CASES [NCASE] = '{
    {3'b000, 4'd3, 4'd0, 1'b1},
    {3'b010, 4'd4, 4'd0, 1'b1},
    {3'b011, 4'd3, 4'd0, 1'b1},
    {3'b100, 4'd3, 4'd0, 1'b1},
    {3'b101, 4'd3, 4'd0, 1'b1},
    {3'b010, 4'd5, 4'd2, 1'b1},
    {3'b011, 4'd4, 4'd1, 1'b1},
    {3'b100, 4'd3, 4'd2, 1'b1},
    {3'b101, 4'd4, 4'd1, 1'b1},
    {3'b100, 4'd4, 4'd2, 1'b0},
    {3'b110, 4'd2, 4'd0, 1'b1}
  };

  logic [66:0] exp_q [16];
  int          n_exp, n_got, gap, rem;
  logic [2:0]  mode;
  int          nw, ab;
  logic        ab_en, accepted, ab_done, meas;
  string       rq;

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [66:0] act, input logic [66:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [63:0] d, input logic s, input logic e, input logic st);
    wr_valid = 1'b1; wr_data = d; wr_sop = s; wr_eop = e; wr_stat = st;
    tick;
    wr_valid = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0; wr_stat = 1'b0;
  endtask

  function automatic string rq_of(input logic [2:0] m);
    case (m)
      3'b011:  return "R6";
      3'b100:  return "R7";
      3'b101:  return "R8";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [63:0] a_word(input int c, input int i);
    return {8'hA0, 40'(c), 16'(i)};
  endfunction
  function automatic logic [63:0] b_word(input int c, input int i);
    return {8'hB0, 40'(c), 16'(i)};
  endfunction
  function automatic logic [63:0] s_word(input int c, input int which);
    return {8'h5A, 40'(c), 16'(which)};
  endfunction

  initial begin : watchdog
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0; wr_sop = 1'b0; wr_eop = 1'b0;
    wr_stat = 1'b0; rd_en = 1'b0; rd_abort = 1'b0; cfg_abort_en = 1'b1;
    cfg_end_mode = 3'b000; cfg_autoclr = 1'b0; disc_clr = 1'b0;
    cfg_wm_thr = {9'd511, 9'd100};
    repeat (3) tick;
    rst_n = 1'b1;
    tick;

    // R1 reset state
    chk("R1 reset outputs", 67'({rd_valid, wr_ovf, disc_flag, wm_out}), 67'(0));

    // table walk: R2, R5..R9, R10 (disabled), R11
    for (int c = 0; c < NCASE; c++) begin
      mode = CASES[c][11:9]; nw = int'(CASES[c][8:5]);
      ab = int'(CASES[c][4:1]); ab_en = CASES[c][0];
      cfg_end_mode = mode; cfg_abort_en = ab_en;
      rq = rq_of(mode);
      accepted = (ab != 0) && ab_en;

      for (int i = 0; i < nw; i++) put(a_word(c, i), i == 0, i == nw - 1, 1'b0);
      put(s_word(c, 0), 1'b0, 1'b0, 1'b1);
      put(b_word(c, 0), 1'b1, 1'b0, 1'b0);
      put(b_word(c, 1), 1'b0, 1'b1, 1'b0);
      put(s_word(c, 1), 1'b0, 1'b0, 1'b1);

      n_exp = 0;
      for (int i = 0; i < (accepted ? ab : nw); i++) begin
        exp_q[n_exp] = {1'b0, i == 0, (i == nw - 1) && (mode != 3'b011), a_word(c, i)};
        n_exp++;
      end
      if (!accepted && (mode == 3'b011 || mode == 3'b100)) begin
        exp_q[n_exp] = {1'b1, 1'b0, mode == 3'b011, s_word(c, 0)}; n_exp++;
      end
      if (accepted && mode == 3'b101) begin
        exp_q[n_exp] = {1'b1, 1'b0, 1'b1, s_word(c, 0)}; n_exp++;
      end
      exp_q[n_exp] = {1'b0, 1'b1, 1'b0, b_word(c, 0)}; n_exp++;
      exp_q[n_exp] = {1'b0, 1'b0, mode != 3'b011, b_word(c, 1)}; n_exp++;
      if (mode == 3'b011 || mode == 3'b100) begin
        exp_q[n_exp] = {1'b1, 1'b0, mode == 3'b011, s_word(c, 1)}; n_exp++;
      end
      rem = nw - ab + ((mode == 3'b011 || mode == 3'b100) ? 1 : 0);

      n_got = 0; ab_done = 1'b0; meas = 1'b0; gap = 0;
      for (int cyc = 0; cyc < 100 && n_got < n_exp; cyc++) begin
        if (meas && rd_valid) begin
          meas = 1'b0;
          chk($sformatf("R9 flush gap case %0d", c), 67'(gap), 67'(rem + 6));
        end else if (meas) begin
          gap++;
        end
        if (ab != 0 && !ab_done && n_got == ab) begin
          rd_abort = 1'b1; rd_en = 1'b0; ab_done = 1'b1; meas = accepted;
        end else begin
          rd_abort = 1'b0; rd_en = 1'b1;
        end
        #1;
        if (rd_en && rd_valid) begin
          chk($sformatf("R2 %s case %0d word %0d", rq, c, n_got),
              {rd_stat, rd_sop, rd_eop, rd_data}, exp_q[n_got]);
          n_got++;
        end
        tick;
      end
      rd_en = 1'b0; rd_abort = 1'b0;
      chk($sformatf("R2 case %0d all words read", c), 67'(n_got), 67'(n_exp));
      repeat (3) tick;
      chk($sformatf("%s case %0d store drained", rq, c), 67'(rd_valid), 67'(0));
      if (ab != 0 && !ab_en)
        chk($sformatf("R10 disabled abort case %0d flag", c), 67'(disc_flag), 67'(0));
      else
        chk($sformatf("R11 discard flag case %0d", c), 67'(disc_flag), 67'(accepted));
      disc_clr = 1'b1; tick; disc_clr = 1'b0;
      chk($sformatf("R11 flag cleared case %0d", c), 67'(disc_flag), 67'(0));
    end

    // R10: abort with no packet in progress
    cfg_end_mode = 3'b000; cfg_abort_en = 1'b1;
    put(64'h500, 1'b1, 1'b0, 1'b0);
    put(64'h501, 1'b0, 1'b1, 1'b0);
    rd_abort = 1'b1; tick; rd_abort = 1'b0;
    chk("R10 idle abort head kept", {rd_valid, rd_sop, disc_flag, rd_data},
        {1'b1, 1'b1, 1'b0, 64'h500});
    rd_en = 1'b1; tick; tick; rd_en = 1'b0;
    chk("R10 idle abort drained", 67'(rd_valid), 67'(0));

    // R12: set beats clear, then auto-clear on next packet start
    cfg_autoclr = 1'b1;
    for (int i = 0; i < 3; i++) put(64'h300 + 64'(i), i == 0, i == 2, 1'b0);
    put(64'h400, 1'b1, 1'b0, 1'b0);
    put(64'h401, 1'b0, 1'b1, 1'b0);
    rd_en = 1'b1; tick; rd_en = 1'b0;
    rd_abort = 1'b1; disc_clr = 1'b1; tick; rd_abort = 1'b0; disc_clr = 1'b0;
    chk("R12 set wins over clear", 67'(disc_flag), 67'(1));
    repeat (8) tick;
    chk("R9 next packet after flush", {rd_valid, rd_sop, rd_data}, {1'b1, 1'b1, 64'h400});
    chk("R11 flag held before auto-clear", 67'(disc_flag), 67'(1));
    rd_en = 1'b1; tick;
    chk("R12 auto-clear on packet start", 67'(disc_flag), 67'(0));
    tick; rd_en = 1'b0; cfg_autoclr = 1'b0;
    chk("R12 store drained", 67'(rd_valid), 67'(0));

    // R3 / R4: fill to capacity, watermarks, overflow
    for (int i = 0; i < 512; i++) begin
      put(64'(i), 1'b0, 1'b0, 1'b0);
      if (i == 99)  chk("R4 lo at count 100", 67'(wm_out), 67'(2'b00));
      if (i == 100) chk("R4 lo at count 101", 67'(wm_out), 67'(2'b01));
      if (i == 510) chk("R4 hi at count 511", 67'(wm_out), 67'(2'b01));
      if (i == 511) chk("R4 hi at count 512", 67'(wm_out), 67'(2'b11));
    end
    wr_valid = 1'b1; wr_data = 64'hDEAD; #1;
    chk("R3 overflow pulse", 67'(wr_ovf), 67'(1));
    tick; wr_valid = 1'b0; #1;
    chk("R3 no pulse when idle", 67'(wr_ovf), 67'(0));
    chk("R3 head intact", {rd_valid, rd_data}, {1'b1, 64'd0});
    rd_en = 1'b1; tick;
    chk("R4 hi drops at count 511", 67'(wm_out), 67'(2'b01));
    for (int k = 1; k < 512; k++) begin
      if (k == 511) chk("R3 last stored word", 67'(rd_data), 67'(511));
      tick;
    end
    rd_en = 1'b0;
    chk("R3 refused word absent", {rd_valid, wm_out}, 67'(0));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule